// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block generates the word addresses for a multi-register load or store. A start strobe captures a 32-bit base address, a 16-bit register-select mask and a walking mode. The block then emits one transfer per cycle. Each transfer carries a register index, a word address and a valid flag. After the last transfer it raises a one-cycle done pulse and presents the updated base for writeback.

The walking mode can be given directly as a direction (up or down) and a timing (step before or after the access). It can also be given as a stack style: full or empty, ascending or descending. The stack style is resolved differently for loads and for stores, so that a push and the matching pop of one stack type walk in opposite ways. Whatever the direction, the transfers visit selected registers from index 0 upward at rising addresses. The lowest selected register always uses the lowest address of the block.

Top module: `blkxfer_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, `xfer_valid_o` and `done_o` are 0.
- R2: A start accepted at a clock edge produces its first transfer in the following cycle. Transfers come one per cycle for every set mask bit, with `xfer_idx_o` giving the bit positions in rising order from 0 to 15.
- R3: Successive transfers step the address by +4, so the lowest selected index takes the lowest address in every mode.
- R4: With `stack_mode_i`=0, `dir_up_i`=1 selects up and `step_pre_i`=1 selects step-before. The first address is base for up-after, base+4 for up-before, base-4n for down-before and base-4(n-1) for down-after, where n is the number of set mask bits.
- R5: `done_o` is high for exactly one cycle, the cycle after the last transfer. With `wb_en_i`=1, `wb_base_o` then holds base+4n in up modes and base-4n in down modes.
- R6: With `wb_en_i`=0, `wb_base_o` equals the base at done.
- R7: With `stack_mode_i`=1 and `is_load_i`=0 (store), where `stk_full_i`=1 means full and `stk_asc_i`=1 means ascending: full-descending walks down-before, full-ascending up-before, empty-descending down-after, and empty-ascending up-after.
- R8: With `stack_mode_i`=1 and `is_load_i`=1 (load): full-descending walks up-after, full-ascending down-after, empty-descending up-before, and empty-ascending down-before.
- R9: An all-zero mask yields no transfers. Done rises in the cycle after the start, with `wb_base_o` equal to the base.
- R10: `start_i` is ignored during the transfer cycles and the done cycle. The running sequence is unaffected, and no new sequence follows the done cycle.
- R11: Bits [1:0] of `xfer_addr_o` are always 0, even for a misaligned base. `wb_base_o` keeps the full base arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register-select mask |
| stack_mode_i | input | 1 | 1: use stack style, 0: use direct mode |
| stk_full_i | input | 1 | Stack style full (1) or empty (0) |
| stk_asc_i | input | 1 | Stack style ascending (1) or descending (0) |
| is_load_i | input | 1 | 1: load, 0: store |
| dir_up_i | input | 1 | Direct mode: 1 up, 0 down |
| step_pre_i | input | 1 | Direct mode: 1 step before, 0 step after |
| wb_en_i | input | 1 | Writeback enable |
| xfer_valid_o | output | 1 | Transfer valid this cycle |
| xfer_idx_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wb_base_o | output | 32 | Updated base, valid with done |

## Verification
The first transfer is due one cycle after the start edge, and transfer k is due k cycles after that. Done follows one cycle after the last transfer, or one cycle after the start for an empty mask. The bench drives start on a falling edge, waits through the accepting rising edge, and samples each result on the next falling edge. It then advances by exactly one clock per expected transfer, and the index sequence is derived by scanning the mask. A separate pass holds start high across a whole sequence and checks that it changes nothing, including in the cycle after done.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_state_e;

  // Resolved walking mode: direction and step timing
  typedef struct packed {
    logic up;
    logic pre;
  } walk_mode_t;

endpackage

// File: rtl/blkxfer_mode_decode.sv
module blkxfer_mode_decode
  import blkxfer_pkg::*;
(
  input  logic       stack_mode_i,
  input  logic       stk_full_i,
  input  logic       stk_asc_i,
  input  logic       is_load_i,
  input  logic       dir_up_i,
  input  logic       step_pre_i,
  output walk_mode_t mode_o
);

  walk_mode_t stk_mode;

  // Stores grow the stack in its own direction; loads undo that exactly.
  always_comb begin
    stk_mode.up  = stk_asc_i  ^ is_load_i;
    stk_mode.pre = stk_full_i ^ is_load_i;
  end

  always_comb begin
    if (stack_mode_i) begin
      mode_o = stk_mode;
    end else begin
      mode_o.up  = dir_up_i;
      mode_o.pre = step_pre_i;
    end
  end

endmodule

// File: rtl/blkxfer_popcount.sv
module blkxfer_popcount #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end

endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);

  logic [W-1:0] iso;

  // Isolate the lowest set bit, then OR-encode its position
  assign iso = vec_i & (~vec_i + W'(1));

  for (genvar b = 0; b < IW; b++) begin : g_enc
    logic [W-1:0] sel;
    for (genvar i = 0; i < W; i++) begin : g_sel
      assign sel[i] = iso[i] & ((i >> b) & 1) == 1;
    end
    assign idx_o[b] = |sel;
  end

endmodule

// File: rtl/blkxfer_addr_seq.sv
module blkxfer_addr_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [NREG-1:0]         mask_i,
  input  logic                    stack_mode_i,
  input  logic                    stk_full_i,
  input  logic                    stk_asc_i,
  input  logic                    is_load_i,
  input  logic                    dir_up_i,
  input  logic                    step_pre_i,
  input  logic                    wb_en_i,
  output logic                    xfer_valid_o,
  output logic [$clog2(NREG)-1:0] xfer_idx_o,
  output logic [ADDR_W-1:0]       xfer_addr_o,
  output logic                    done_o,
  output logic [ADDR_W-1:0]       wb_base_o
);

  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam int WA_W  = ADDR_W - 2;

  walk_mode_t         mode;
  logic [CNT_W-1:0]   sel_cnt;
  logic [IDX_W-1:0]   low_idx;

  seq_state_e         state_q, state_d;
  logic [NREG-1:0]    rem_q, rem_d;
  logic [WA_W-1:0]    addr_q, addr_d;
  logic [ADDR_W-1:0]  wb_q, wb_d;
  logic               rem_en, addr_en, wb_en;

  logic [WA_W-1:0]    base_w, cnt_w, first_w;
  logic [ADDR_W-1:0]  span_b, wb_calc;

  blkxfer_mode_decode u_mode (
    .stack_mode_i (stack_mode_i),
    .stk_full_i   (stk_full_i),
    .stk_asc_i    (stk_asc_i),
    .is_load_i    (is_load_i),
    .dir_up_i     (dir_up_i),
    .step_pre_i   (step_pre_i),
    .mode_o       (mode)
  );

  blkxfer_popcount #(.W(NREG), .CW(CNT_W)) u_cnt (
    .vec_i (mask_i),
    .cnt_o (sel_cnt)
  );

  blkxfer_lowbit #(.W(NREG), .IW(IDX_W)) u_low (
    .vec_i (rem_q),
    .idx_o (low_idx)
  );

  // Start address and writeback value, in words and bytes
  always_comb begin
    base_w = base_i[ADDR_W-1:2];
    cnt_w  = WA_W'(sel_cnt);
    span_b = ADDR_W'(sel_cnt) << 2;
    unique case ({mode.up, mode.pre})
      2'b10:   first_w = base_w;
      2'b11:   first_w = base_w + WA_W'(1);
      2'b01:   first_w = base_w - cnt_w;
      default: first_w = base_w - cnt_w + WA_W'(1);
    endcase
    if (!wb_en_i)     wb_calc = base_i;
    else if (mode.up) wb_calc = base_i + span_b;
    else              wb_calc = base_i - span_b;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    wb_d    = wb_q;
    rem_en  = 1'b0;
    addr_en = 1'b0;
    wb_en   = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          rem_d   = mask_i;
          addr_d  = first_w;
          wb_d    = wb_calc;
          rem_en  = 1'b1;
          addr_en = 1'b1;
          wb_en   = 1'b1;
          state_d = (|mask_i) ? SQ_RUN : SQ_FIN;
        end
      end
      SQ_RUN: begin
        rem_d   = rem_q & (rem_q - NREG'(1));
        addr_d  = addr_q + WA_W'(1);
        rem_en  = 1'b1;
        addr_en = 1'b1;
        if (rem_d == '0) state_d = SQ_FIN;
      end
      SQ_FIN:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en)  rem_q  <= rem_d;
      if (addr_en) addr_q <= addr_d;
      if (wb_en)   wb_q   <= wb_d;
    end
  end

  assign xfer_valid_o = (state_q == SQ_RUN);
  assign xfer_idx_o   = low_idx;
  assign xfer_addr_o  = {addr_q, 2'b00};
  assign done_o       = (state_q == SQ_FIN);
  assign wb_base_o    = wb_q;

endmodule

// File: rtl/blkxfer_addr_seq_chk.sv
module blkxfer_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    xfer_valid_o,
  input logic [$clog2(NREG)-1:0] xfer_idx_o,
  input logic [ADDR_W-1:0]       xfer_addr_o,
  input logic                    done_o
);

  p_addr_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> xfer_addr_o[1:0] == 2'b00);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_valid_o, done_o}));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o)) |->
      xfer_addr_o == $past(xfer_addr_o) + ADDR_W'(4));

  p_idx_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o)) |-> xfer_idx_o > $past(xfer_idx_o));

  p_run_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |=> (xfer_valid_o || done_o));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !xfer_valid_o);

endmodule

bind blkxfer_addr_seq blkxfer_addr_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xfer_valid_o (xfer_valid_o),
  .xfer_idx_o   (xfer_idx_o),
  .xfer_addr_o  (xfer_addr_o),
  .done_o       (done_o)
);

// File: tb/blkxfer_addr_seq_test.sv
module blkxfer_addr_seq_test;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] base_i;
  logic [15:0] mask_i;
  logic        stack_mode_i, stk_full_i, stk_asc_i, is_load_i;
  logic        dir_up_i, step_pre_i, wb_en_i;
  logic        xfer_valid_o;
  logic [3:0]  xfer_idx_o;
  logic [31:0] xfer_addr_o;
  logic        done_o;
  logic [31:0] wb_base_o;

  int checks = 0;
  int errors = 0;

  blkxfer_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
    .stack_mode_i(stack_mode_i), .stk_full_i(stk_full_i), .stk_asc_i(stk_asc_i),
    .is_load_i(is_load_i), .dir_up_i(dir_up_i), .step_pre_i(step_pre_i),
    .wb_en_i(wb_en_i), .xfer_valid_o(xfer_valid_o), .xfer_idx_o(xfer_idx_o),
    .xfer_addr_o(xfer_addr_o), .done_o(done_o), .wb_base_o(wb_base_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] mask;
    logic        stk, full, asc, load, up, pre, wb;
    logic [31:0] first;
    logic [31:0] wbx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // direct modes (R4, R5, R6)
    '{32'h1000, 16'h000E, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 1'b1, 32'h0FF8, 32'h0FF4},
    '{32'h2000, 16'h8001, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b1, 32'h2000, 32'h2008},
    '{32'h2000, 16'h00F0, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1, 32'h2004, 32'h2010},
    '{32'h3000, 16'h0005, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 1'b1, 32'h2FF8, 32'h2FF8},
    '{32'h4000, 16'hFFFF, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b1, 1'b0, 32'h3FC0, 32'h4000},
    // stores by stack style (R7)
    '{32'h5000, 16'h0003, 1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1, 1'b1, 32'h4FF8, 32'h4FF8},
    '{32'h5000, 16'h0007, 1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1, 1'b1, 32'h5000, 32'h500C},
    '{32'h7000, 16'h0001, 1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0, 1'b1, 32'h7004, 32'h7004},
    '{32'h7000, 16'h0001, 1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 1'b1, 32'h7000, 32'h6FFC},
    // loads by stack style (R8)
    '{32'h4FF8, 16'h0003, 1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1, 1'b1, 32'h4FF8, 32'h5000},
    '{32'h500C, 16'h0007, 1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0, 1'b1, 32'h5000, 32'h5000},
    '{32'h6000, 16'h0100, 1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1, 1'b1, 32'h6000, 32'h5FFC},
    '{32'h6000, 16'h0300, 1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0, 1'b1, 32'h6004, 32'h6008},
    // misaligned base (R11)
    '{32'h8003, 16'h0003, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 1'b1, 32'h8000, 32'h800B}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input vec_t v);
    base_i = v.base; mask_i = v.mask; stack_mode_i = v.stk;
    stk_full_i = v.full; stk_asc_i = v.asc; is_load_i = v.load;
    dir_up_i = v.up; step_pre_i = v.pre; wb_en_i = v.wb;
  endtask

  // Entered at a falling edge with the design idle
  task automatic run_vec(input vec_t v, input string tag);
    int k;
    apply(v);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (v.mask[i]) begin
        check({tag, " R2 valid"}, 32'(xfer_valid_o), 32'd1);
        check({tag, " R2 index"}, 32'(xfer_idx_o), i);
        check({tag, " R3/R4 address"}, xfer_addr_o, v.first + 32'(4 * k));
        k++;
        @(negedge clk);
      end
    end
    check({tag, " R5 done"}, 32'(done_o), 32'd1);
    check({tag, " R5 valid low at done"}, 32'(xfer_valid_o), 32'd0);
    check({tag, " R5/R6 writeback"}, wb_base_o, v.wbx);
    @(negedge clk);
    check({tag, " R5 done single"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0; start_i = 1'b0;
    apply(VEC[0]);
    @(negedge clk);
    check("R1 valid in reset", 32'(xfer_valid_o), 32'd0);
    check("R1 done in reset", 32'(done_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid idle", 32'(xfer_valid_o), 32'd0);
    check("R1 done idle", 32'(done_o), 32'd0);

    for (int n = 0; n < NV; n++) begin
      run_vec(VEC[n], $sformatf("vec%0d", n));
    end

    // R9: empty mask
    v = VEC[3];
    v.base = 32'h1234; v.mask = 16'h0000;
    apply(v);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    check("R9 done at once", 32'(done_o), 32'd1);
    check("R9 no transfer", 32'(xfer_valid_o), 32'd0);
    check("R9 writeback is base", wb_base_o, 32'h1234);
    @(negedge clk);
    check("R9 no late transfer", 32'(xfer_valid_o), 32'd0);

    // R10: start held high through a running sequence and its done cycle
    v = VEC[1];
    v.mask = 16'h000F; v.wbx = 32'h2010;
    apply(v);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    base_i = 32'h9000; mask_i = 16'h0001; dir_up_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check("R10 index unaffected", 32'(xfer_idx_o), i);
      check("R10 address unaffected", xfer_addr_o, 32'h2000 + 32'(4 * i));
      @(negedge clk);
    end
    check("R10 done", 32'(done_o), 32'd1);
    check("R10 writeback unaffected", wb_base_o, 32'h2010);
    start_i = 1'b0;
    @(negedge clk);
    check("R10 no new sequence valid", 32'(xfer_valid_o), 32'd0);
    check("R10 no new sequence done", 32'(done_o), 32'd0);
    @(negedge clk);
    check("R10 still idle", 32'(xfer_valid_o), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule